// File: doc/BRIEF.md
# Register-Programmed Half-Duplex SPI Master

This block is a serial-peripheral master that software drives through eight 16-bit registers. Each transfer moves data in one direction only. A write shifts a word of 4 to 32 bits out on the data-out line, and a read shifts a word of the same range in from the data-in line. Software sets up the shift clock and the interrupt behaviour, loads the transmit half-words, and then writes a control word that names the direction, the word length and the target device.

Completion is reported by one sticky flag for each direction. These flags drive an interrupt line whose polarity and whose level-or-pulse behaviour can be programmed. Words of eight bits or fewer are always carried as 16-bit shifts. A start command issued while the shift clock is gated off is held until the clock is enabled.

Top module: `spi_regmaster`

## Requirements
- R1: Registers sit at byte offsets (address bit 0 ignored). 0x0 setup: bit0 shift-clock enable, bits3:1 divider code, bit4 write-done interrupt enable, bit5 read-done interrupt enable. 0x2 options: bit0 active edge (1 rising, 0 falling), bit5 interrupt polarity (1 active high), bit10 trigger (1 pulse, 0 level). 0x4 control: bit0 read, bit1 write, bits6:2 length minus one, bit7 device select. 0x6 status: bit1 write done, bit0 read done. 0x8 and 0xA hold the transmit low and high halves, 0xC and 0xE the receive low and high halves. After reset every register reads 0, both chip selects are high, the clock rests at its idle level, and the interrupt output is high.
- R2: A write shifts the 32-bit value {high half, low half} out MSB first, starting at bit 15 of the high half. The word is N bits long. Each bit is driven at the start of its bit time and is held for the whole bit.
- R3: N equals length-minus-one plus 1 when that sum is 9 or more. Otherwise N is 16, so a short word must sit in the upper bits of the high half.
- R4: A read clears the receive value at the start and samples the data-in line at each active edge. The last bit lands in receive bit 0, the low half holds the last 16 bits, and the high half holds the earlier bits.
- R5: The clock rests at the inverse of the active-edge level. Each bit spends one half period at rest and one at the active level. A half period is 2^(2*code+1) clock cycles, so a transfer lasts 2*N*2^(2*code+1) cycles, and code 7 divides by 2^16.
- R6: While the clock enable is 0, the shift clock does not toggle and no transfer begins. A start written in that state is held and shown in its control bit, and it begins once the enable is set.
- R7: During a transfer only the selected chip-select output is low. Both are high when idle.
- R8: A completed write sets status bit1 and a completed read sets status bit0. Writing status clears each flag whose written bit is 0. A write leaves the receive registers unchanged, and a read holds data-out low.
- R9: In level mode the interrupt request is (write-done AND its enable) OR (read-done AND its enable). The output equals the request when polarity is 1 and its inverse when polarity is 0.
- R10: In pulse mode the output is active for exactly one cycle each time the request rises.
- R11: A control write is ignored while a transfer is running or a start is held. If both direction bits are set, a write is performed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational from reg_addr |
| sclk | output | 1 | Shift clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 2 | Active-low chip selects |
| irq | output | 1 | Interrupt output |

## Verification
Assertions check the following on every cycle:
- at most one chip select is low, and none is low when idle;
- the shift clock and engine never advance while the enable is clear;
- data-out stays low during reads;
- a completion pulse coincides with the end of a transfer;
- a status flag rises only with a completion;
- a pulse-mode interrupt never lasts two cycles.

Only the bench scenarios can show the following:
- bit order and length stretching for short words;
- exact transfer duration per divider code;
- where received bits land in the two halves;
- held starts, ignored control writes, write priority;
- the interrupt level and pulse under both polarities.

// File: rtl/spi_rm_pkg.sv
package spi_rm_pkg;
  localparam int REG_W  = 16;
  localparam int WORD_W = 32;
  localparam int DIV_W  = 3;
  localparam int LEN_W  = 5;
  localparam int BITC_W = 6;

  localparam logic [2:0] IX_SETUP = 3'd0;
  localparam logic [2:0] IX_OPT   = 3'd1;
  localparam logic [2:0] IX_CTRL  = 3'd2;
  localparam logic [2:0] IX_STAT  = 3'd3;
  localparam logic [2:0] IX_TXL   = 3'd4;
  localparam logic [2:0] IX_TXH   = 3'd5;
  localparam logic [2:0] IX_RXL   = 3'd6;
  localparam logic [2:0] IX_RXH   = 3'd7;

  localparam int CTRL_CS_LSB = 7;

  typedef struct packed {
    logic             clk_en;
    logic [DIV_W-1:0] div;
    logic             ie_w;
    logic             ie_r;
    logic             edge_sel;
    logic             pol;
    logic             trig_edge;
  } cfg_t;
endpackage

// File: rtl/spi_rm_regs.sv
module spi_rm_regs
  import spi_rm_pkg::*;
#(
  parameter int CS_W = 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic [2:0]          idx,
  input  logic [REG_W-1:0]    wdata,
  output logic [REG_W-1:0]    rdata,
  output cfg_t                cfg,
  output logic                pend,
  output logic                pend_wr,
  output logic [LEN_W-1:0]    len_m1,
  output logic [CS_W-1:0]     cs_sel,
  output logic [WORD_W-1:0]   tx_data,
  input  logic                start_ack,
  input  logic                busy,
  input  logic                done_wr,
  input  logic                done_rd,
  input  logic [WORD_W-1:0]   rx_data,
  output logic                wflag,
  output logic                rflag
);
  cfg_t              cfg_d;
  logic              pend_d, pend_wr_d, wflag_d, rflag_d;
  logic [LEN_W-1:0]  len_d;
  logic [CS_W-1:0]   cs_d;
  logic [REG_W-1:0]  txl_q, txh_q, txl_d, txh_d;
  logic              ctrl_take;
  logic              unused_wbits;

  assign unused_wbits = &{1'b0, wdata};
  assign ctrl_take = reg_wr && (idx == IX_CTRL) && !pend && !busy;

  always_comb begin
    cfg_d     = cfg;
    pend_d    = pend;
    pend_wr_d = pend_wr;
    len_d     = len_m1;
    cs_d      = cs_sel;
    txl_d     = txl_q;
    txh_d     = txh_q;
    wflag_d   = wflag;
    rflag_d   = rflag;
    if (start_ack) pend_d = 1'b0;
    if (reg_wr) begin
      case (idx)
        IX_SETUP: begin
          cfg_d.clk_en = wdata[0];
          cfg_d.div    = wdata[DIV_W:1];
          cfg_d.ie_w   = wdata[4];
          cfg_d.ie_r   = wdata[5];
        end
        IX_OPT: begin
          cfg_d.edge_sel  = wdata[0];
          cfg_d.pol       = wdata[5];
          cfg_d.trig_edge = wdata[10];
        end
        IX_STAT: begin
          wflag_d = wflag & wdata[1];
          rflag_d = rflag & wdata[0];
        end
        IX_TXL:  txl_d = wdata;
        IX_TXH:  txh_d = wdata;
        default: ;
      endcase
    end
    if (ctrl_take) begin
      pend_d    = wdata[0] | wdata[1];
      pend_wr_d = wdata[1];
      len_d     = wdata[LEN_W+1:2];
      cs_d      = wdata[CTRL_CS_LSB +: CS_W];
    end
    if (done_wr) wflag_d = 1'b1;
    if (done_rd) rflag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg     <= '0;
      pend    <= 1'b0;
      pend_wr <= 1'b0;
      len_m1  <= '0;
      cs_sel  <= '0;
      txl_q   <= '0;
      txh_q   <= '0;
      wflag   <= 1'b0;
      rflag   <= 1'b0;
    end else begin
      cfg     <= cfg_d;
      pend    <= pend_d;
      pend_wr <= pend_wr_d;
      len_m1  <= len_d;
      cs_sel  <= cs_d;
      txl_q   <= txl_d;
      txh_q   <= txh_d;
      wflag   <= wflag_d;
      rflag   <= rflag_d;
    end
  end

  assign tx_data = {txh_q, txl_q};

  always_comb begin
    rdata = '0;
    case (idx)
      IX_SETUP: rdata[5:0] = {cfg.ie_r, cfg.ie_w, cfg.div, cfg.clk_en};
      IX_OPT: begin
        rdata[0]  = cfg.edge_sel;
        rdata[5]  = cfg.pol;
        rdata[10] = cfg.trig_edge;
      end
      IX_CTRL: begin
        rdata[0] = pend & ~pend_wr;
        rdata[1] = pend & pend_wr;
        rdata[LEN_W+1:2] = len_m1;
        rdata[CTRL_CS_LSB +: CS_W] = cs_sel;
      end
      IX_STAT: rdata[1:0] = {wflag, rflag};
      IX_TXL:  rdata = txl_q;
      IX_TXH:  rdata = txh_q;
      IX_RXL:  rdata = rx_data[REG_W-1:0];
      default: rdata = rx_data[WORD_W-1:REG_W];
    endcase
  end

  // R8: a flag rises only from a completion pulse
  p_flag_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wflag) |-> $past(done_wr));
  // R11: a held start keeps its direction until accepted
  p_pend_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !start_ack) |=> (pend && $stable(pend_wr) && $stable(len_m1)));
endmodule

// File: rtl/spi_rm_engine.sv
module spi_rm_engine
  import spi_rm_pkg::*;
#(
  parameter int NUM_CS = 2,
  parameter int CS_W   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en,
  input  logic [DIV_W-1:0]  div,
  input  logic              edge_sel,
  input  logic              start_req,
  input  logic              req_wr,
  input  logic [LEN_W-1:0]  len_m1,
  input  logic [CS_W-1:0]   cs_sel,
  input  logic [WORD_W-1:0] tx_data,
  input  logic              miso,
  output logic              start_ack,
  output logic              busy,
  output logic              done_wr,
  output logic              done_rd,
  output logic [WORD_W-1:0] rx_data,
  output logic              sclk,
  output logic              mosi,
  output logic [NUM_CS-1:0] cs_n
);
  localparam int CNT_W = 2 * ((1 << DIV_W) - 1) + 1;

  logic              busy_q, busy_d, phase_q, phase_d, dir_q, dir_d;
  logic              dwr_d, drd_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [CNT_W:0]    lim_w;
  logic [BITC_W-1:0] bits_q, bits_d, nbits;
  logic [WORD_W-1:0] txsr_q, txsr_d, rxsr_q, rxsr_d;
  logic [CS_W-1:0]   cs_q, cs_d;
  logic              half_last;

  assign start_ack = start_req && clk_en && !busy_q;
  assign lim_w     = ({{CNT_W{1'b0}}, 1'b1} << (2 * div + 1)) - 1'b1;
  assign half_last = (cnt_q == lim_w[CNT_W-1:0]);
  assign nbits     = (len_m1 < LEN_W'(8)) ? BITC_W'(16) : BITC_W'(len_m1) + 1'b1;

  always_comb begin
    busy_d  = busy_q;
    phase_d = phase_q;
    dir_d   = dir_q;
    cnt_d   = cnt_q;
    bits_d  = bits_q;
    txsr_d  = txsr_q;
    rxsr_d  = rxsr_q;
    cs_d    = cs_q;
    dwr_d   = 1'b0;
    drd_d   = 1'b0;
    if (start_ack) begin
      busy_d  = 1'b1;
      phase_d = 1'b0;
      cnt_d   = '0;
      bits_d  = nbits;
      dir_d   = req_wr;
      cs_d    = cs_sel;
      txsr_d  = req_wr ? tx_data : '0;
      if (!req_wr) rxsr_d = '0;
    end else if (busy_q && clk_en) begin
      if (!half_last) begin
        cnt_d = cnt_q + 1'b1;
      end else begin
        cnt_d = '0;
        if (!phase_q) begin
          phase_d = 1'b1;
          if (!dir_q) rxsr_d = {rxsr_q[WORD_W-2:0], miso};
        end else begin
          phase_d = 1'b0;
          txsr_d  = {txsr_q[WORD_W-2:0], 1'b0};
          if (bits_q == BITC_W'(1)) begin
            busy_d = 1'b0;
            dwr_d  = dir_q;
            drd_d  = !dir_q;
          end else begin
            bits_d = bits_q - 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      phase_q <= 1'b0;
      dir_q   <= 1'b0;
      cnt_q   <= '0;
      bits_q  <= '0;
      txsr_q  <= '0;
      rxsr_q  <= '0;
      cs_q    <= '0;
      done_wr <= 1'b0;
      done_rd <= 1'b0;
    end else begin
      busy_q  <= busy_d;
      phase_q <= phase_d;
      dir_q   <= dir_d;
      cnt_q   <= cnt_d;
      bits_q  <= bits_d;
      txsr_q  <= txsr_d;
      rxsr_q  <= rxsr_d;
      cs_q    <= cs_d;
      done_wr <= dwr_d;
      done_rd <= drd_d;
    end
  end

  assign busy    = busy_q;
  assign rx_data = rxsr_q;
  assign sclk    = edge_sel ? phase_q : ~phase_q;
  assign mosi    = busy_q && dir_q && txsr_q[WORD_W-1];

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    assign cs_n[g] = !(busy_q && (cs_q == CS_W'(g)));
  end

  // R7: never more than one device selected, none when idle
  p_one_cs_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n) && (busy_q || (&cs_n)));
  // R6: no clock progress while the enable is clear
  p_clk_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en && busy_q) |=> ($stable(phase_q) && $stable(bits_q)));
  // R6: a transfer begins only with the enable set
  p_start_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(clk_en));
  // R8: data-out stays low for a read
  p_read_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !dir_q) |-> !mosi);
  // R8: completion coincides with the end of a transfer
  p_done_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_wr || done_rd) |-> $fell(busy_q));
endmodule

// File: rtl/spi_rm_irq.sv
module spi_rm_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic wflag,
  input  logic rflag,
  input  logic ie_w,
  input  logic ie_r,
  input  logic pol,
  input  logic trig_edge,
  output logic irq
);
  logic req, req_q, pulse, act;

  assign req   = (wflag & ie_w) | (rflag & ie_r);
  assign pulse = req & ~req_q;
  assign act   = trig_edge ? pulse : req;
  assign irq   = pol ? act : ~act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req;
  end

  // R10: a pulse never lasts two cycles
  p_pulse_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse);
endmodule

// File: rtl/spi_regmaster.sv
module spi_regmaster
  import spi_rm_pkg::*;
#(
  parameter int NUM_CS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [3:0]        reg_addr,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic [NUM_CS-1:0] cs_n,
  output logic              irq
);
  localparam int CS_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;

  cfg_t              cfg;
  logic              pend, pend_wr, start_ack, busy, done_wr, done_rd;
  logic              wflag, rflag;
  logic [LEN_W-1:0]  len_m1;
  logic [CS_W-1:0]   cs_sel;
  logic [WORD_W-1:0] tx_data, rx_data;
  logic              unused_a0;

  assign unused_a0 = reg_addr[0];

  spi_rm_regs #(.CS_W(CS_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .idx(reg_addr[3:1]),
    .wdata(reg_wdata), .rdata(reg_rdata), .cfg(cfg), .pend(pend),
    .pend_wr(pend_wr), .len_m1(len_m1), .cs_sel(cs_sel), .tx_data(tx_data),
    .start_ack(start_ack), .busy(busy), .done_wr(done_wr), .done_rd(done_rd),
    .rx_data(rx_data), .wflag(wflag), .rflag(rflag)
  );

  spi_rm_engine #(.NUM_CS(NUM_CS), .CS_W(CS_W)) u_engine (
    .clk(clk), .rst_n(rst_n), .clk_en(cfg.clk_en), .div(cfg.div),
    .edge_sel(cfg.edge_sel), .start_req(pend), .req_wr(pend_wr),
    .len_m1(len_m1), .cs_sel(cs_sel), .tx_data(tx_data), .miso(miso),
    .start_ack(start_ack), .busy(busy), .done_wr(done_wr), .done_rd(done_rd),
    .rx_data(rx_data), .sclk(sclk), .mosi(mosi), .cs_n(cs_n)
  );

  spi_rm_irq u_irq (
    .clk(clk), .rst_n(rst_n), .wflag(wflag), .rflag(rflag),
    .ie_w(cfg.ie_w), .ie_r(cfg.ie_r), .pol(cfg.pol),
    .trig_edge(cfg.trig_edge), .irq(irq)
  );
endmodule

// File: tb/spi_regmaster_test.sv
`timescale 1ns/1ps
module spi_regmaster_test;
  logic clk = 1'b0;
  logic rst_n;
  logic reg_wr;
  logic [3:0] reg_addr;
  logic [15:0] reg_wdata, reg_rdata;
  logic sclk, mosi, miso;
  logic [1:0] cs_n;
  logic irq;

  int n_chk = 0, n_bad = 0;
  logic [31:0] slv_sr, cap, exp_rx;
  logic act_edge;
  int cs0_cnt, cs1_cnt, irq_cnt;
  logic g_pol, g_trig, g_iew, g_ier, g_dir;
  logic [1:0] g_stat;
  int g_n, g_h, g_cs;
  logic [31:0] g_tx, g_sd;
  int seed_dummy;

  spi_regmaster uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sclk(sclk), .mosi(mosi),
    .miso(miso), .cs_n(cs_n), .irq(irq)
  );

  always #2.5 clk = ~clk;

  assign miso = slv_sr[31];

  always @(sclk) begin
    if (cs_n != 2'b11 && sclk == act_edge) begin
      #1;
      cap    = {cap[30:0], mosi};
      slv_sr = slv_sr << 1;
    end
  end

  always @(negedge clk) begin
    if (cs_n[0] == 1'b0) cs0_cnt++;
    if (cs_n[1] == 1'b0) cs1_cnt++;
    if (irq == g_pol) irq_cnt++;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  function automatic logic [31:0] mask_n(input int n);
    logic [63:0] m;
    m = (64'd1 << n) - 64'd1;
    return m[31:0];
  endfunction

  function automatic int eff_len(input int lenf);
    return (lenf + 1 <= 8) ? 16 : lenf + 1;
  endfunction

  task automatic start_xfer(input logic [1:0] dbits, input int lenf, input int dv,
                            input logic edg, input int cs, input logic [31:0] tx,
                            input logic [31:0] sd, input logic iew, input logic ier,
                            input logic pol, input logic trig);
    wr(4'h2, {5'd0, trig, 4'd0, pol, 4'd0, edg});
    act_edge = edg;
    g_pol = pol; g_trig = trig; g_iew = iew; g_ier = ier;
    wr(4'h0, {10'd0, ier, iew, 3'(dv), 1'b1});
    wr(4'h8, tx[15:0]);
    wr(4'hA, tx[31:16]);
    g_n = eff_len(lenf);
    g_h = 1 << (2 * dv + 1);
    g_dir = dbits[1];
    g_cs = cs; g_tx = tx; g_sd = sd;
    slv_sr = sd << (32 - g_n);
    cap = '0;
    @(negedge clk);
    cs0_cnt = 0; cs1_cnt = 0; irq_cnt = 0;
    wr(4'h4, {7'd0, 1'(cs), 5'(lenf), dbits});
  endtask

  task automatic wait_flag(input logic [1:0] fm);
    logic [15:0] s;
    for (int i = 0; i < 80000; i++) begin
      rd(4'h6, s);
      if ((s[1:0] & fm) != 0) break;
    end
  endtask

  task automatic finish_xfer(input bit clr);
    logic [15:0] s, rl, rh;
    logic [31:0] expd;
    logic rq;
    int sel_cnt, oth_cnt;
    wait_flag(g_dir ? 2'b10 : 2'b01);
    repeat (3) @(negedge clk);
    g_stat = g_stat | (g_dir ? 2'b10 : 2'b01);
    rd(4'h6, s);
    chk(s[1:0] == g_stat, "R8 status flags", s, g_stat);
    sel_cnt = (g_cs == 0) ? cs0_cnt : cs1_cnt;
    oth_cnt = (g_cs == 0) ? cs1_cnt : cs0_cnt;
    chk(sel_cnt == 2 * g_n * g_h, "R5 R3 transfer length in cycles", sel_cnt, 2 * g_n * g_h);
    chk(oth_cnt == 0, "R7 unselected line quiet", oth_cnt, 0);
    if (g_dir) begin
      expd = (g_tx >> (32 - g_n)) & mask_n(g_n);
      chk((cap & mask_n(g_n)) == expd, "R2 shifted-out bits", cap & mask_n(g_n), expd);
    end else begin
      chk(cap == 0, "R8 data-out low on read", cap, 0);
      exp_rx = g_sd & mask_n(g_n);
    end
    rd(4'hC, rl);
    rd(4'hE, rh);
    chk({rh, rl} == exp_rx, "R4 R8 receive halves", {rh, rl}, exp_rx);
    rq = (g_stat[1] & g_iew) | (g_stat[0] & g_ier);
    if (g_trig) begin
      chk(irq_cnt == (((g_dir ? g_iew : g_ier)) ? 1 : 0), "R10 single pulse", irq_cnt,
          (g_dir ? g_iew : g_ier) ? 1 : 0);
    end else begin
      chk(irq == (rq ? g_pol : !g_pol), "R9 level output", irq, rq ? g_pol : !g_pol);
    end
    if (clr) begin
      wr(4'h6, 16'h0000);
      g_stat = 2'b00;
      @(negedge clk);
      chk(irq == !g_pol, "R9 output inactive after clear", irq, !g_pol);
    end
  endtask

  initial begin
    #(5.0 * 190000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] v;
    logic s0;
    seed_dummy = $urandom(32'd77123);
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    slv_sr = '0; cap = '0; act_edge = 1'b0; exp_rx = '0; g_stat = 2'b00;
    g_pol = 1'b0; g_trig = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    for (int a = 0; a < 16; a += 2) begin
      rd(4'(a), v);
      chk(v == 16'h0, "R1 reset register value", v, 0);
    end
    chk(cs_n == 2'b11, "R1 R7 reset chip selects", cs_n, 3);
    chk(sclk == 1'b1, "R1 R5 reset clock idle level", sclk, 1);
    chk(irq == 1'b1, "R1 R9 reset interrupt", irq, 1);

    // directed: 8-bit write carried as 16 bits (R3)
    start_xfer(2'b10, 7, 0, 1'b1, 0, 32'hA500_1234, 32'h0, 1'b1, 1'b0, 1'b1, 1'b0);
    finish_xfer(1'b1);
    // directed: 4-bit read carried as 16 bits (R3, R4)
    start_xfer(2'b01, 3, 0, 1'b0, 1, 32'h0, 32'h0000_BEEF, 1'b0, 1'b1, 1'b0, 1'b1);
    finish_xfer(1'b1);
    // directed: 32-bit read fills both halves (R4)
    start_xfer(2'b01, 31, 1, 1'b1, 0, 32'h0, 32'hC0DE_5A5A, 1'b0, 1'b1, 1'b1, 1'b0);
    finish_xfer(1'b1);

    // random transfers
    for (int i = 0; i < 40; i++) begin
      logic [31:0] rt, rs;
      logic [1:0] db;
      rt = $urandom; rs = $urandom;
      db = ($urandom % 2) ? 2'b10 : 2'b01;
      start_xfer(db, 3 + ($urandom % 29), $urandom % 2, 1'($urandom), $urandom % 2,
                 rt, rs, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
      finish_xfer(1'b1);
    end

    // R6: start held while the clock is gated
    wr(4'h2, 16'h0000);
    act_edge = 1'b0; g_pol = 1'b0; g_trig = 1'b0; g_iew = 1'b0; g_ier = 1'b0;
    wr(4'h0, 16'h0000);
    g_n = 20; g_h = 2; g_dir = 1'b1; g_cs = 1; g_tx = 32'h9F31_0C47; g_sd = '0;
    wr(4'h8, g_tx[15:0]);
    wr(4'hA, g_tx[31:16]);
    cap = '0;
    @(negedge clk);
    cs0_cnt = 0; cs1_cnt = 0;
    s0 = sclk;
    wr(4'h4, {7'd0, 1'b1, 5'd19, 2'b10});
    repeat (40) @(negedge clk);
    chk(cs1_cnt == 0 && cs0_cnt == 0, "R6 no transfer while gated", cs1_cnt, 0);
    chk(sclk == s0, "R6 clock stays at rest", sclk, s0);
    rd(4'h4, v);
    chk(v[1] == 1'b1, "R6 start shown as held", v[1], 1);
    rd(4'h6, v);
    chk(v[1:0] == 2'b00, "R6 no completion while gated", v, 0);
    wr(4'h0, 16'h0001);
    finish_xfer(1'b1);

    // R11: control write during a transfer is ignored
    start_xfer(2'b10, 31, 1, 1'b0, 0, 32'h1357_9BDF, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0);
    repeat (40) @(negedge clk);
    wr(4'h4, {7'd0, 1'b1, 5'd15, 2'b01});
    finish_xfer(1'b1);
    cs0_cnt = 0; cs1_cnt = 0;
    repeat (100) @(negedge clk);
    chk(cs0_cnt == 0 && cs1_cnt == 0, "R11 ignored command never runs", cs1_cnt, 0);

    // R11: both direction bits give a write
    start_xfer(2'b11, 11, 0, 1'b1, 1, 32'hF0F0_0000, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b1, 1'b0);
    finish_xfer(1'b1);

    // R8: selective clear of status flags
    start_xfer(2'b10, 15, 0, 1'b1, 0, 32'h00FF_0000, 32'h0, 1'b1, 1'b1, 1'b1, 1'b0);
    finish_xfer(1'b0);
    start_xfer(2'b01, 15, 0, 1'b1, 0, 32'h0, 32'h0000_1111, 1'b1, 1'b1, 1'b1, 1'b0);
    finish_xfer(1'b0);
    wr(4'h6, 16'h0001);
    rd(4'h6, v);
    chk(v[1:0] == 2'b01, "R8 selective status clear", v, 1);
    chk(irq == 1'b1, "R9 remaining read flag keeps request", irq, 1);
    wr(4'h6, 16'h0000);
    g_stat = 2'b00;
    rd(4'h6, v);
    chk(v[1:0] == 2'b00, "R8 status fully cleared", v, 0);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule